// File: doc/BRIEF.md
# H-Bridge Non-Overlap Gate Generator

This block sits between two one-bit switching modulators and two full H-bridges. Each bridge has a positive leg and a negative leg, and each leg has a high-side and a low-side switch. The block turns each modulator's bit into the four gate commands of its bridge. The positive leg follows the bit and the negative leg follows its complement, so the load sees a differential drive. On every change of side, a leg first turns both of its switches off for a programmable number of clock cycles and only then turns the new switch on.

A 3-bit code selects the dead interval. A mono input steers the left modulator's bit into the right bridge as well, so that the two bridges can be wired in parallel to carry twice the current. An enable from the power sequencer turns every gate off at once. When enable returns, each leg starts again from a full dead interval before it turns any switch on.

Top module: `hbridge_gate_gen`

## Requirements
- R1: A leg never has its high-side and low-side gates on together, and it never turns one off and the other on at the same clock edge.
- R2: The dead interval is `dt_sel + 1` clock cycles, with `dt_sel` read as an unsigned number whose bit 2 is the most significant. Code 0 gives 1 cycle and code 7 gives 8 cycles. Across the interval both gates of the leg read 0.
- R3: `dt_sel` is sampled only at the edge that opens a dead interval. A change while the interval is running does not shorten it or lengthen it, and the new code applies from the next transition.
- R4: Gate bit order within each 4-bit gate bus is [0] positive high, [1] positive low, [2] negative high, [3] negative low. For a modulator bit of 1 the settled bus is 4'b1001, and for a bit of 0 it is 4'b0110.
- R5: With `mono` = 1 the right bridge follows `mod_l` and `mod_r` has no effect. With `mono` = 0 each bridge follows its own modulator bit.
- R6: When `enable` is sampled low at an edge, all eight gates are 0 after that edge, and they stay 0 while `enable` remains low.
- R7: When `enable` is first sampled high after being low (or after reset), the gates stay 0 for `dt_sel + 1` cycles after that edge. At the edge after that, they turn on to match the modulator bit.
- R8: Synchronous active-low reset sets all gates to 0.
- R9: If the modulator bit changes while a dead interval runs, the leg takes the side given by the bit sampled at the edge that closes the interval, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Sequencer enable; low forces every gate off |
| mono | input | 1 | 1: both bridges follow `mod_l` |
| dt_sel | input | 3 | Dead-time code, interval = code + 1 cycles |
| mod_l | input | 1 | Left modulator decision bit |
| mod_r | input | 1 | Right modulator decision bit |
| gate_l | output | 4 | Left bridge gates {neg low, neg high, pos low, pos high} |
| gate_r | output | 4 | Right bridge gates {neg low, neg high, pos low, pos high} |

## Verification
The bench measures the off window at every one of the eight codes. A counter that is one short or one long shows up there as a wrong cycle count, and a leg that swaps sides directly shows up as a zero-length window. It changes the code in the middle of an interval, which exposes a design that reads `dt_sel` continuously: the interval it measures comes out shorter. It flips the modulator bit back during an interval, which catches a leg that latched its target at the start. It sets `mod_r` against `mod_l` in mono mode, which catches a leaky mux. It drops enable and releases reset mid-stream, which catches a design that resumes without a fresh dead interval and turns a gate on too early.

// File: rtl/hbg_pkg.sv
// Package hbg_pkg
// Shared types for the H-bridge gate generator.
// Assumes: one leg has exactly two switches, high side and low side.
package hbg_pkg;

    // Leg state: both off (idle or disabled), timing a gap, high on, low on.
    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_GAP  = 2'd1,
        LEG_HIGH = 2'd2,
        LEG_LOW  = 2'd3
    } leg_state_t;

    localparam int LEGS_PER_BRIDGE  = 2;
    localparam int GATES_PER_LEG    = 2;
    localparam int GATES_PER_BRIDGE = LEGS_PER_BRIDGE * GATES_PER_LEG;

endpackage

// File: rtl/hbg_leg.sv
// Module hbg_leg
// One half-bridge leg with its own dead-time counter. When the requested side
// differs from the side that is on, both gates go off for dt_sel+1 cycles and
// then the side sampled at the closing edge turns on.
// Assumes: dt_sel is static only in the sense that it is sampled when a gap opens.
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] dt_sel,
    input  logic             drive_hi,
    output logic             gate_hi,
    output logic             gate_lo
);

    localparam int RUN_W = SEL_W + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    leg_state_t       state_q, state_n;
    logic [SEL_W-1:0] cnt_q, cnt_n;

    // Next-state: open a gap on any change of side, close it when the count ends.
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (!enable) begin
            state_n = LEG_OFF;
        end else begin
            case (state_q)
                LEG_OFF: begin
                    state_n = LEG_GAP;
                    cnt_n   = dt_sel;
                end
                LEG_HIGH: if (!drive_hi) begin
                    state_n = LEG_GAP;
                    cnt_n   = dt_sel;
                end
                LEG_LOW: if (drive_hi) begin
                    state_n = LEG_GAP;
                    cnt_n   = dt_sel;
                end
                LEG_GAP: begin
                    if (cnt_q == '0) state_n = drive_hi ? LEG_HIGH : LEG_LOW;
                    else             cnt_n   = cnt_q - 1'b1;
                end
                default: state_n = LEG_OFF;
            endcase
        end
    end

    // State register with synchronous reset to all-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LEG_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    assign gate_hi = (state_q == LEG_HIGH);
    assign gate_lo = (state_q == LEG_LOW);

    // Checker state: length of the current all-off run, and the length owed.
    logic [RUN_W-1:0] off_run_q;
    logic [RUN_W-1:0] need_q;

    // Count cycles with both gates off; note the code each time a gap opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_run_q <= '0;
            need_q    <= '0;
        end else begin
            if (!gate_hi && !gate_lo)
                off_run_q <= (off_run_q == RUN_MAX) ? RUN_MAX : off_run_q + 1'b1;
            else
                off_run_q <= '0;
            if (state_n == LEG_GAP && state_q != LEG_GAP)
                need_q <= RUN_W'(dt_sel) + 1'b1;
        end
    end

    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_hi) || $fell(gate_lo)) |-> (!gate_hi && !gate_lo)); // R1

    AST_FULL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) || $rose(gate_lo)) |-> (off_run_q >= need_q)); // R2

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (!gate_hi && !gate_lo)); // R6

endmodule

// File: rtl/hbg_bridge.sv
// Module hbg_bridge
// One full H-bridge: the positive leg follows the modulator bit and the
// negative leg follows its complement. Gate bus order per leg is {low, high}.
// Assumes: both legs share enable and dt_sel, so they switch in step.
module hbg_bridge
    import hbg_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic [SEL_W-1:0]            dt_sel,
    input  logic                        mod_bit,
    output logic [GATES_PER_BRIDGE-1:0] gates
);

    logic [LEGS_PER_BRIDGE-1:0] leg_drive;

    // Leg 0 is the positive leg, leg 1 the negative (inverted) leg.
    always_comb begin
        leg_drive[0] = mod_bit;
        leg_drive[1] = ~mod_bit;
    end

    for (genvar i = 0; i < LEGS_PER_BRIDGE; i++) begin : g_leg
        hbg_leg #(.SEL_W(SEL_W)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (enable),
            .dt_sel   (dt_sel),
            .drive_hi (leg_drive[i]),
            .gate_hi  (gates[GATES_PER_LEG*i]),
            .gate_lo  (gates[GATES_PER_LEG*i+1])
        );
    end

    AST_LEGS_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates[0] && gates[2]) && !(gates[1] && gates[3])); // R4

endmodule

// File: rtl/hbridge_gate_gen.sv
// Module hbridge_gate_gen
// Two H-bridge gate generators with programmable dead time. In mono mode the
// left modulator bit drives both bridges so they can be paralleled.
// Assumes: mod_l/mod_r/mono are synchronous to clk.
module hbridge_gate_gen
    import hbg_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic                        mono,
    input  logic [SEL_W-1:0]            dt_sel,
    input  logic                        mod_l,
    input  logic                        mod_r,
    output logic [GATES_PER_BRIDGE-1:0] gate_l,
    output logic [GATES_PER_BRIDGE-1:0] gate_r
);

    localparam int NUM_BRIDGE = 2;

    logic [NUM_BRIDGE-1:0]       br_bit;
    logic [GATES_PER_BRIDGE-1:0] br_gates [NUM_BRIDGE];

    // Bridge source select: right bridge takes the left bit in mono mode.
    always_comb begin
        br_bit[0] = mod_l;
        br_bit[1] = mono ? mod_l : mod_r;
    end

    for (genvar b = 0; b < NUM_BRIDGE; b++) begin : g_bridge
        hbg_bridge #(.SEL_W(SEL_W)) u_bridge (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (enable),
            .dt_sel  (dt_sel),
            .mod_bit (br_bit[b]),
            .gates   (br_gates[b])
        );
    end

    assign gate_l = br_gates[0];
    assign gate_r = br_gates[1];

endmodule

// File: tb/sim_hbridge_gate_gen.sv
module sim_hbridge_gate_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable;
    logic       mono;
    logic [2:0] dt_sel;
    logic       mod_l;
    logic       mod_r;
    logic [3:0] gate_l;
    logic [3:0] gate_r;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hbridge_gate_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mono(mono),
        .dt_sel(dt_sel), .mod_l(mod_l), .mod_r(mod_r),
        .gate_l(gate_l), .gate_r(gate_r)
    );

    // {en, mono, sel[2:0], mod_l, mod_r, exp_l[3:0], exp_r[3:0]}
    localparam int NV = 14;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 4'h0, 4'h0},
        {1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 4'h9, 4'h6},
        {1'b1, 1'b0, 3'd0, 1'b1, 1'b0, 4'h9, 4'h6},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 4'h0, 4'h6},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 4'h6, 4'h0},
        {1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 4'h6, 4'h9},
        {1'b1, 1'b1, 3'd0, 1'b1, 1'b1, 4'h0, 4'h9},
        {1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 4'h6, 4'h0},
        {1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 4'h6, 4'h6},
        {1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 4'h6, 4'h6},
        {1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 4'h0, 4'h0},
        {1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 4'h0, 4'h0},
        {1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 4'h0, 4'h0},
        {1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 4'h9, 4'h9}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts samples with gate_l all off after the stimulus edge; returns the
    // count and the first non-zero bus. Optionally rewrites dt_sel mid-gap.
    task automatic gap_measure(input int chg_at, input logic [2:0] new_sel,
                               output int n, output logic [3:0] last);
        n = 0;
        last = 4'h0;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if (gate_l != 4'h0) begin
                last = gate_l;
                break;
            end
            n++;
            if (n == chg_at) dt_sel = new_sel;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [3:0] last;
        rst_n = 1'b0; enable = 1'b0; mono = 1'b0; dt_sel = 3'd0;
        mod_l = 1'b0; mod_r = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(gate_l == 4'h0 && gate_r == 4'h0, "R8 reset", {gate_l, gate_r}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            {enable, mono, dt_sel, mod_l, mod_r} = VEC[i][14:8];
            @(negedge clk);
            check(gate_l == VEC[i][7:4], $sformatf("R4 R5 R6 R9 step %0d left", i),
                  gate_l, VEC[i][7:4]);
            check(gate_r == VEC[i][3:0], $sformatf("R4 R5 R6 R9 step %0d right", i),
                  gate_r, VEC[i][3:0]);
        end

        // R2 and R1: every code, alternating direction; left now 4'h9
        for (int s = 0; s < 8; s++) begin
            logic [3:0] want;
            dt_sel = 3'(s);
            mod_l  = ~mod_l;
            want   = mod_l ? 4'h9 : 4'h6;
            gap_measure(-1, 3'd0, n, last);
            check(n == s + 1, $sformatf("R2 gap length code %0d", s), n, s + 1);
            check(last == want, $sformatf("R1 side after gap code %0d", s), last, want);
        end
        check(gate_r == 4'h9, "R5 right untouched by left", gate_r, 9);

        // R3: code changed mid-gap keeps the running length, applies next time
        dt_sel = 3'd7;
        mod_l  = ~mod_l;
        gap_measure(2, 3'd0, n, last);
        check(n == 8, "R3 mid-gap code change ignored", n, 8);
        mod_l = ~mod_l;
        gap_measure(-1, 3'd0, n, last);
        check(n == 1, "R3 new code used on next transition", n, 1);

        // R6: drop enable while on; R7 re-enable restarts the gap
        enable = 1'b0;
        @(negedge clk);
        check(gate_l == 4'h0 && gate_r == 4'h0, "R6 disable forces off", {gate_l, gate_r}, 0);
        mod_l = ~mod_l;
        @(negedge clk);
        check(gate_l == 4'h0, "R6 stays off while disabled", gate_l, 0);
        enable = 1'b1;
        dt_sel = 3'd5;
        gap_measure(-1, 3'd0, n, last);
        check(n == 6, "R7 re-enable gap code 5", n, 6);
        check(last == (mod_l ? 4'h9 : 4'h6), "R7 side after re-enable", last,
              mod_l ? 9 : 6);

        // R8: reset mid-run, then R7 start-up gap after release
        rst_n = 1'b0;
        @(negedge clk);
        check(gate_l == 4'h0 && gate_r == 4'h0, "R8 reset mid-run", {gate_l, gate_r}, 0);
        dt_sel = 3'd3;
        rst_n  = 1'b1;
        gap_measure(-1, 3'd0, n, last);
        check(n == 4, "R7 gap after reset release code 3", n, 4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule